// File: doc/BRIEF.md
# Coherence Directory Controller

This block is the central bookkeeper for cache coherence among a small group of processor caches that share one memory. For every memory line it records one of three states: no cached copy, a set of caches holding clean copies (kept as a presence bit per processor), or one cache holding the line for writing (kept as an owner index). Cache controllers send it requests. It answers each one with a grant, after it has first told other caches to drop or write back their copies where coherence calls for that.

Requests arrive on a valid/ready channel and are served one at a time. Invalidate and write-back commands leave on a second valid/ready channel, one target cache per transfer, in ascending processor order. Each commanded cache answers on an acknowledge channel that is always accepted. A grant leaves on a third valid/ready channel only once every awaited acknowledge has arrived. A cache that drops a line reports it with an eviction request, which updates the table and produces no grant.

Top module: `coh_directory`

## Requirements
- R1: After reset every line is uncached, `req_ready` is high and neither `cmd_valid` nor `gnt_valid` is asserted, so a first write request to any line is granted with no commands.
- R2: A read request (`req_op` = 0) to a line that is uncached or shared is granted with `gnt_excl` = 0 and no commands, `gnt_proc`/`gnt_line` echo the request, and the requester is recorded as a holder.
- R3: A write-permission request (`req_op` = 1) sends an invalidate command (`cmd_op` = 0) to every recorded holder except the requester, exactly once each and in ascending processor index, and never to the requester.
- R4: The write grant (`gnt_excl` = 1) appears one clock after the last awaited acknowledge is taken, never earlier, and the line then has the requester as its only holder.
- R5: A write-permission request from a processor that is the only sharer of the line is granted one clock after acceptance with no commands.
- R6: A read request to a line owned for writing by another processor sends one write-back command (`cmd_op` = 1) to the owner only, and the grant (`gnt_excl` = 0) follows one clock after the owner's acknowledge.
- R7: After such a write-back the line is shared by the former owner and the reader, so a later write request by the reader invalidates only the former owner.
- R8: An eviction report (`req_op` = 2 or 3) removes the sender from the holders without any grant or command; `req_ready` stays high, and a line left with no holder becomes uncached.
- R9: From the clock after a read or write request is accepted until one clock after its grant is taken, `req_ready` is low; a request needing no commands is granted one clock after acceptance.
- R10: An acknowledge from a processor that has not been sent a command in the current transaction, or is no longer awaited, is ignored.
- R11: A read or write request from the processor that already owns the line for writing is granted at once with `gnt_excl` = 1 and no commands.
- R12: While `gnt_ready` is low, `gnt_valid` stays high and the grant fields stay unchanged; the same holds for a command while `cmd_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and taking a request |
| req_proc | input | $clog2(NPROC) | Requesting processor |
| req_line | input | $clog2(NLINES) | Line index |
| req_op | input | 2 | 0 read, 1 write permission, 2 or 3 eviction report |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Target cache takes the command |
| cmd_proc | output | $clog2(NPROC) | Target processor |
| cmd_line | output | $clog2(NLINES) | Line index of the command |
| cmd_op | output | 1 | 0 invalidate, 1 write back |
| ack_valid | input | 1 | Acknowledge from a cache |
| ack_proc | input | $clog2(NPROC) | Processor acknowledging |
| gnt_valid | output | 1 | Grant present |
| gnt_ready | input | 1 | Requester takes the grant |
| gnt_proc | output | $clog2(NPROC) | Granted processor |
| gnt_line | output | $clog2(NLINES) | Granted line |
| gnt_excl | output | 1 | 1 when write permission is granted |

## Verification
A request that needs no commands shows its grant one clock after the acceptance edge. Otherwise the first command follows one clock after acceptance and the others come on successive clocks. The grant is due exactly one clock after the edge that takes the last awaited acknowledge, and `req_ready` rises one clock after the grant is taken. The bench drives inputs and samples outputs on the falling edge and numbers each falling edge from acceptance. It holds acknowledges back for several clocks and compares the grant's edge number with the number of the last acknowledge plus one, so a grant that comes early or late is caught.

// File: rtl/cohdir_pkg.sv
package cohdir_pkg;

  typedef enum logic [1:0] {
    LN_UNCACHED = 2'd0,
    LN_SHARED   = 2'd1,
    LN_OWNED    = 2'd2
  } line_state_e;

  typedef enum logic [1:0] {
    CT_IDLE  = 2'd0,
    CT_SEND  = 2'd1,
    CT_WAIT  = 2'd2,
    CT_GRANT = 2'd3
  } ctl_state_e;

  localparam logic [1:0] RQ_READ  = 2'd0;
  localparam logic [1:0] RQ_WRITE = 2'd1;

  localparam logic CM_INVAL = 1'b0;
  localparam logic CM_WBACK = 1'b1;

endpackage

// File: rtl/dir_table.sv
module dir_table
  import cohdir_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int NLINES = 16,
  localparam int PW = $clog2(NPROC),
  localparam int LW = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LW-1:0]     rd_line,
  output line_state_e       rd_state,
  output logic [NPROC-1:0]  rd_vec,
  output logic [PW-1:0]     rd_owner,
  input  logic              wr_en,
  input  logic [LW-1:0]     wr_line,
  input  line_state_e       wr_state,
  input  logic [NPROC-1:0]  wr_vec,
  input  logic [PW-1:0]     wr_owner
);

  line_state_e      st_all  [NLINES];
  logic [NPROC-1:0] vec_all [NLINES];
  logic [PW-1:0]    own_all [NLINES];

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    line_state_e      st_r;
    logic [NPROC-1:0] vec_r;
    logic [PW-1:0]    own_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_r  <= LN_UNCACHED;
        vec_r <= '0;
        own_r <= '0;
      end else if (wr_en && wr_line == LW'(g)) begin
        st_r  <= wr_state;
        vec_r <= wr_vec;
        own_r <= wr_owner;
      end
    end

    assign st_all[g]  = st_r;
    assign vec_all[g] = vec_r;
    assign own_all[g] = own_r;
  end

  assign rd_state = st_all[rd_line];
  assign rd_vec   = vec_all[rd_line];
  assign rd_owner = own_all[rd_line];

endmodule

// File: rtl/dir_decide.sv
module dir_decide
  import cohdir_pkg::*;
#(
  parameter int NPROC = 4,
  localparam int PW = $clog2(NPROC)
) (
  input  logic [1:0]        op,
  input  logic [PW-1:0]     proc,
  input  line_state_e       cur_state,
  input  logic [NPROC-1:0]  cur_vec,
  input  logic [PW-1:0]     cur_owner,
  output logic [NPROC-1:0]  tgt_mask,
  output logic              tgt_op,
  output line_state_e       nxt_state,
  output logic [NPROC-1:0]  nxt_vec,
  output logic [PW-1:0]     nxt_owner,
  output logic              gnt_needed,
  output logic              gnt_excl
);

  function automatic logic [NPROC-1:0] as_onehot(input logic [PW-1:0] idx);
    return NPROC'(1) << idx;
  endfunction

  logic [NPROC-1:0] self_oh;
  logic [NPROC-1:0] owner_oh;
  logic [NPROC-1:0] left_vec;
  logic             self_owns;

  assign self_oh   = as_onehot(proc);
  assign owner_oh  = as_onehot(cur_owner);
  assign left_vec  = cur_vec & ~self_oh;
  assign self_owns = (cur_state == LN_OWNED) && (cur_owner == proc);

  always_comb begin
    tgt_mask   = '0;
    tgt_op     = CM_INVAL;
    nxt_state  = cur_state;
    nxt_vec    = cur_vec;
    nxt_owner  = cur_owner;
    gnt_needed = 1'b1;
    gnt_excl   = 1'b0;
    if (op[1]) begin
      gnt_needed = 1'b0;
      if (cur_state == LN_SHARED) begin
        nxt_vec   = left_vec;
        nxt_state = (left_vec == '0) ? LN_UNCACHED : LN_SHARED;
      end else if (self_owns) begin
        nxt_state = LN_UNCACHED;
        nxt_vec   = '0;
      end
    end else if (op == RQ_READ) begin
      case (cur_state)
        LN_SHARED: nxt_vec = cur_vec | self_oh;
        LN_OWNED: begin
          if (self_owns) begin
            gnt_excl = 1'b1;
          end else begin
            tgt_mask  = owner_oh;
            tgt_op    = CM_WBACK;
            nxt_state = LN_SHARED;
            nxt_vec   = owner_oh | self_oh;
          end
        end
        default: begin
          nxt_state = LN_SHARED;
          nxt_vec   = self_oh;
        end
      endcase
    end else begin
      gnt_excl  = 1'b1;
      nxt_state = LN_OWNED;
      nxt_vec   = self_oh;
      nxt_owner = proc;
      case (cur_state)
        LN_SHARED: tgt_mask = left_vec;
        LN_OWNED:  tgt_mask = self_owns ? '0 : owner_oh;
        default:   tgt_mask = '0;
      endcase
    end
  end

endmodule

// File: rtl/dir_pick.sv
module dir_pick #(
  parameter int NPROC = 4,
  localparam int PW = $clog2(NPROC)
) (
  input  logic [NPROC-1:0] mask,
  output logic             any,
  output logic [PW-1:0]    idx
);

  function automatic logic [PW-1:0] lowest_set(input logic [NPROC-1:0] m);
    logic [PW-1:0] r;
    r = '0;
    for (int i = NPROC - 1; i >= 0; i--) begin
      if (m[i]) r = PW'(i);
    end
    return r;
  endfunction

  assign any = |mask;
  assign idx = lowest_set(mask);

endmodule

// File: rtl/coh_directory.sv
module coh_directory
  import cohdir_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int NLINES = 16,
  localparam int PW = $clog2(NPROC),
  localparam int LW = $clog2(NLINES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [PW-1:0]  req_proc,
  input  logic [LW-1:0]  req_line,
  input  logic [1:0]     req_op,
  output logic           cmd_valid,
  input  logic           cmd_ready,
  output logic [PW-1:0]  cmd_proc,
  output logic [LW-1:0]  cmd_line,
  output logic           cmd_op,
  input  logic           ack_valid,
  input  logic [PW-1:0]  ack_proc,
  output logic           gnt_valid,
  input  logic           gnt_ready,
  output logic [PW-1:0]  gnt_proc,
  output logic [LW-1:0]  gnt_line,
  output logic           gnt_excl
);

  function automatic logic [NPROC-1:0] as_onehot(input logic [PW-1:0] idx);
    return NPROC'(1) << idx;
  endfunction

  ctl_state_e       st_q;
  logic [PW-1:0]    proc_q;
  logic [LW-1:0]    line_q;
  logic [NPROC-1:0] send_q;
  logic [NPROC-1:0] await_q;
  logic             op_q;
  logic             excl_q;
  line_state_e      ns_q;
  logic [NPROC-1:0] nv_q;
  logic [PW-1:0]    no_q;

  line_state_e      tb_state;
  logic [NPROC-1:0] tb_vec;
  logic [PW-1:0]    tb_owner;

  logic [NPROC-1:0] d_tgt;
  logic             d_cmdop;
  line_state_e      d_state;
  logic [NPROC-1:0] d_vec;
  logic [PW-1:0]    d_owner;
  logic             d_gnt;
  logic             d_excl;

  logic             pk_any;
  logic [PW-1:0]    pk_idx;

  // named internal events, also watched by the checker
  logic             ev_accept;
  logic             ev_fast;
  logic             ev_silent;
  logic             ev_cmd_fire;
  logic [NPROC-1:0] ack_oh;
  logic             ev_ack_hit;
  logic [NPROC-1:0] await_nxt;
  logic             ev_all_acked;
  logic             ev_grant_fire;
  logic [NPROC-1:0] send_left;

  logic             wr_en;
  logic [LW-1:0]    wr_line;
  line_state_e      wr_state;
  logic [NPROC-1:0] wr_vec;
  logic [PW-1:0]    wr_owner;

  dir_table #(.NPROC(NPROC), .NLINES(NLINES)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_line  (req_line),
    .rd_state (tb_state),
    .rd_vec   (tb_vec),
    .rd_owner (tb_owner),
    .wr_en    (wr_en),
    .wr_line  (wr_line),
    .wr_state (wr_state),
    .wr_vec   (wr_vec),
    .wr_owner (wr_owner)
  );

  dir_decide #(.NPROC(NPROC)) u_decide (
    .op         (req_op),
    .proc       (req_proc),
    .cur_state  (tb_state),
    .cur_vec    (tb_vec),
    .cur_owner  (tb_owner),
    .tgt_mask   (d_tgt),
    .tgt_op     (d_cmdop),
    .nxt_state  (d_state),
    .nxt_vec    (d_vec),
    .nxt_owner  (d_owner),
    .gnt_needed (d_gnt),
    .gnt_excl   (d_excl)
  );

  dir_pick #(.NPROC(NPROC)) u_pick (
    .mask (send_q),
    .any  (pk_any),
    .idx  (pk_idx)
  );

  assign req_ready = (st_q == CT_IDLE);
  assign cmd_valid = (st_q == CT_SEND) && pk_any;
  assign cmd_proc  = pk_idx;
  assign cmd_line  = line_q;
  assign cmd_op    = op_q;
  assign gnt_valid = (st_q == CT_GRANT);
  assign gnt_proc  = proc_q;
  assign gnt_line  = line_q;
  assign gnt_excl  = excl_q;

  assign ev_accept     = req_valid && req_ready;
  assign ev_fast       = ev_accept && d_gnt && (d_tgt == '0);
  assign ev_silent     = ev_accept && !d_gnt;
  assign ev_cmd_fire   = cmd_valid && cmd_ready;
  assign send_left     = send_q & ~as_onehot(pk_idx);
  // only a processor already commanded and still awaited may count
  assign ack_oh        = ack_valid ? (as_onehot(ack_proc) & await_q & ~send_q) : '0;
  assign ev_ack_hit    = (st_q != CT_IDLE) && (ack_oh != '0);
  assign await_nxt     = await_q & ~ack_oh;
  assign ev_all_acked  = (st_q == CT_WAIT) && (await_nxt == '0);
  assign ev_grant_fire = gnt_valid && gnt_ready;

  assign wr_en    = ev_fast || ev_silent || ev_all_acked;
  assign wr_line  = ev_accept ? req_line : line_q;
  assign wr_state = ev_accept ? d_state  : ns_q;
  assign wr_vec   = ev_accept ? d_vec    : nv_q;
  assign wr_owner = ev_accept ? d_owner  : no_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CT_IDLE;
      proc_q  <= '0;
      line_q  <= '0;
      send_q  <= '0;
      await_q <= '0;
      op_q    <= CM_INVAL;
      excl_q  <= 1'b0;
      ns_q    <= LN_UNCACHED;
      nv_q    <= '0;
      no_q    <= '0;
    end else begin
      case (st_q)
        CT_IDLE: begin
          if (ev_accept) begin
            proc_q  <= req_proc;
            line_q  <= req_line;
            op_q    <= d_cmdop;
            excl_q  <= d_excl;
            ns_q    <= d_state;
            nv_q    <= d_vec;
            no_q    <= d_owner;
            send_q  <= d_tgt;
            await_q <= d_tgt;
            if (ev_fast) begin
              st_q <= CT_GRANT;
            end else if (d_gnt) begin
              st_q <= CT_SEND;
            end
          end
        end
        CT_SEND: begin
          await_q <= await_nxt;
          if (ev_cmd_fire) begin
            send_q <= send_left;
            if (send_left == '0) st_q <= CT_WAIT;
          end
        end
        CT_WAIT: begin
          await_q <= await_nxt;
          if (ev_all_acked) st_q <= CT_GRANT;
        end
        default: begin
          if (ev_grant_fire) st_q <= CT_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/coh_directory_chk.sv
module coh_directory_chk #(
  parameter int NPROC  = 4,
  parameter int NLINES = 16,
  localparam int PW = $clog2(NPROC),
  localparam int LW = $clog2(NLINES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    req_op,
  input logic          req_ready,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [PW-1:0] cmd_proc,
  input logic          cmd_op,
  input logic          gnt_valid,
  input logic          gnt_ready,
  input logic [PW-1:0] gnt_proc,
  input logic [LW-1:0] gnt_line,
  input logic          gnt_excl,
  input logic [PW-1:0] proc_q,
  input logic          ev_accept,
  input logic          ev_cmd_fire,
  input logic          ev_ack_hit
);

  logic [PW+1:0] outstanding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outstanding <= '0;
    else outstanding <= outstanding + (PW+2)'(ev_cmd_fire) - (PW+2)'(ev_ack_hit);
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!cmd_valid && !gnt_valid)); // R9

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && !req_op[1]) |=> !req_ready); // R9

  AST_EVICT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && req_op[1]) |=> (req_ready && !gnt_valid)); // R8

  AST_GNT_AFTER_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (outstanding == '0)); // R4

  AST_NO_SELF_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_proc != proc_q)); // R3

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_proc) && $stable(cmd_op))); // R12

  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !gnt_ready) |=>
      (gnt_valid && $stable(gnt_proc) && $stable(gnt_line) && $stable(gnt_excl))); // R12

endmodule

bind coh_directory coh_directory_chk #(.NPROC(NPROC), .NLINES(NLINES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_op      (req_op),
  .req_ready   (req_ready),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_proc    (cmd_proc),
  .cmd_op      (cmd_op),
  .gnt_valid   (gnt_valid),
  .gnt_ready   (gnt_ready),
  .gnt_proc    (gnt_proc),
  .gnt_line    (gnt_line),
  .gnt_excl    (gnt_excl),
  .proc_q      (proc_q),
  .ev_accept   (ev_accept),
  .ev_cmd_fire (ev_cmd_fire),
  .ev_ack_hit  (ev_ack_hit)
);

// File: tb/test_coh_directory.sv
module test_coh_directory;

  localparam int NPROC  = 4;
  localparam int NLINES = 16;
  localparam int PW = $clog2(NPROC);
  localparam int LW = $clog2(NLINES);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [PW-1:0] req_proc = '0;
  logic [LW-1:0] req_line = '0;
  logic [1:0]    req_op = '0;
  logic          cmd_valid;
  logic          cmd_ready = 1'b1;
  logic [PW-1:0] cmd_proc;
  logic [LW-1:0] cmd_line;
  logic          cmd_op;
  logic          ack_valid = 1'b0;
  logic [PW-1:0] ack_proc = '0;
  logic          gnt_valid;
  logic          gnt_ready = 1'b1;
  logic [PW-1:0] gnt_proc;
  logic [LW-1:0] gnt_line;
  logic          gnt_excl;

  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  coh_directory #(.NPROC(NPROC), .NLINES(NLINES)) i_coh_directory (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_proc  (req_proc),
    .req_line  (req_line),
    .req_op    (req_op),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_proc  (cmd_proc),
    .cmd_line  (cmd_line),
    .cmd_op    (cmd_op),
    .ack_valid (ack_valid),
    .ack_proc  (ack_proc),
    .gnt_valid (gnt_valid),
    .gnt_ready (gnt_ready),
    .gnt_proc  (gnt_proc),
    .gnt_line  (gnt_line),
    .gnt_excl  (gnt_excl)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  // vector: proc, line, op, expected command mask, command op, grant, exclusive
  function automatic logic [14:0] mkv(input int p, input int l, input int op,
                                      input int m, input int co, input int g,
                                      input int x);
    return {2'(p), 4'(l), 2'(op), 4'(m), 1'(co), 1'(g), 1'(x)};
  endfunction

  localparam int NV = 16;
  localparam logic [14:0] VEC [NV] = '{
    mkv(0, 3, 0, 4'b0000, 0, 1, 0),  // R2 uncached read
    mkv(1, 3, 0, 4'b0000, 0, 1, 0),  // R2 shared read
    mkv(2, 3, 0, 4'b0000, 0, 1, 0),  // R2
    mkv(1, 3, 1, 4'b0101, 0, 1, 1),  // R3 R4 invalidate P0,P2
    mkv(1, 3, 1, 4'b0000, 0, 1, 1),  // R11 owner writes again
    mkv(3, 3, 0, 4'b0010, 1, 1, 0),  // R6 write-back from P1
    mkv(3, 3, 1, 4'b0010, 0, 1, 1),  // R7 only former owner invalidated
    mkv(3, 3, 2, 4'b0000, 0, 0, 0),  // R8 owner evicts
    mkv(0, 3, 1, 4'b0000, 0, 1, 1),  // R8 line uncached again
    mkv(2, 5, 0, 4'b0000, 0, 1, 0),  // R2
    mkv(2, 5, 1, 4'b0000, 0, 1, 1),  // R5 sole sharer
    mkv(0, 3, 0, 4'b0000, 0, 1, 1),  // R11 owner reads
    mkv(1, 3, 0, 4'b0001, 1, 1, 0),  // R6
    mkv(1, 3, 3, 4'b0000, 0, 0, 0),  // R8 sharer evicts (code 3)
    mkv(2, 3, 1, 4'b0001, 0, 1, 1),  // R8 only P0 left
    mkv(0, 9, 1, 4'b0000, 0, 1, 1)   // R1 untouched line
  };

  task automatic run(input int p, input int l, input int op, input int m,
                     input int co, input int g, input int x,
                     input int hold, input int spur);
    int seen = 0;
    int ackq = 0;
    int cyc = 1;
    int last_ack = -10;
    int prev = -1;
    int gcyc = -1;
    int hold_left = hold;
    bit got = 0;
    bit done = 0;
    bit bad_order = 0;
    bit bad_op = 0;
    bit bad_fields = 0;
    bit busy_bad = 0;
    bit early = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready before request", int'(req_ready), 1);
    req_valid = 1'b1;
    req_proc  = PW'(p);
    req_line  = LW'(l);
    req_op    = 2'(op);
    gnt_ready = (hold == 0);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && cyc < 100) begin
      ack_valid = 1'b0;
      if (cmd_valid) begin
        seen |= (1 << cmd_proc);
        if (int'(cmd_op) != co) bad_op = 1;
        if (int'(cmd_proc) <= prev || int'(cmd_line) != l) bad_order = 1;
        prev = int'(cmd_proc);
        ackq |= (1 << cmd_proc);
      end
      if (gnt_valid) begin
        if (!got) begin
          got = 1;
          gcyc = cyc;
          if (ackq != 0) early = 1;
        end
        if (int'(gnt_proc) != p || int'(gnt_line) != l || int'(gnt_excl) != x)
          bad_fields = 1;
        if (hold_left > 0) begin
          hold_left--;
          gnt_ready = 1'b0;
        end else begin
          gnt_ready = 1'b1;
          done = 1;
        end
      end else if (g != 0 && req_ready) begin
        busy_bad = 1;
      end
      if (spur >= 0 && cyc == 1) begin
        ack_valid = 1'b1;
        ack_proc  = PW'(spur);
      end else if (cyc >= 5 && ackq != 0) begin
        for (int i = NPROC - 1; i >= 0; i--) if (ackq[i]) ack_proc = PW'(i);
        ack_valid = 1'b1;
        ackq &= ~(1 << ack_proc);
        last_ack = cyc;
      end
      if (g == 0 && cyc >= 3) done = 1;
      @(negedge clk);
      cyc++;
    end
    ack_valid = 1'b0;
    gnt_ready = 1'b1;
    if (co == 1) chk(seen == m, "R6", "write-back target mask", seen, m);
    else         chk(seen == m, "R3", "invalidate target mask", seen, m);
    chk(!bad_order, "R3", "ascending commands on the request line", int'(bad_order), 0);
    chk(!bad_op, (co == 1) ? "R6" : "R3", "command code", int'(bad_op), 0);
    chk(got == bit'(g), (g == 0) ? "R8" : "R2", "grant present", int'(got), g);
    chk(!early, "R4", "grant before every ack", int'(early), 0);
    chk(!bad_fields, (x != 0) ? "R11" : "R2", "grant fields", int'(bad_fields), 0);
    chk(!busy_bad, "R9", "ready low while busy", int'(busy_bad), 0);
    if (g != 0 && m == 0) chk(gcyc == 1, "R9", "no-command grant latency", gcyc, 1);
    if (g != 0 && m != 0) chk(gcyc == last_ack + 1, "R4", "grant after last ack", gcyc, last_ack + 1);
    chk(req_ready == 1'b1, "R9", "ready after completion", int'(req_ready), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL R9 watchdog: actual hung expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet reset state
    chk(req_ready == 1'b1 && !cmd_valid && !gnt_valid, "R1", "reset outputs",
        {29'd0, req_ready, cmd_valid, gnt_valid}, 4);
    rst_n = 1'b1;
    @(negedge clk);
    run(2, 12, 1, 0, 0, 1, 1, 0, -1);  // R1 first write: no commands

    for (int v = 0; v < NV; v++) begin
      logic [14:0] e;
      e = VEC[v];
      run(int'(e[14:13]), int'(e[12:9]), int'(e[8:7]), int'(e[6:3]),
          int'(e[2]), int'(e[1]), int'(e[0]), 0, -1);
    end

    // R10: stray ack from P2 while P1 and P3 are awaited
    run(3, 7, 0, 0, 0, 1, 0, 0, -1);
    run(0, 7, 0, 0, 0, 1, 0, 0, -1);
    run(1, 7, 0, 0, 0, 1, 0, 0, -1);
    run(0, 7, 1, 4'b1010, 0, 1, 1, 0, 2);
    // R10: the stray ack did not count, line is owned by P0 alone
    run(3, 7, 0, 4'b0001, 1, 1, 0, 0, -1);

    // R12: grant held with gnt_ready low
    run(1, 8, 1, 0, 0, 1, 1, 3, -1);
    run(2, 8, 1, 4'b0010, 0, 1, 1, 2, -1);

    summary();
    $finish;
  end

endmodule